// File: doc/BRIEF.md
# UART Receive Character Buffer with Hysteretic Flow Control

This block is the receive side of a single UART channel. It sits after the serial deserializer. Each finished character arrives on a valid/ready stream with eight data bits and three per-character error flags. The block stores the characters in a first-in first-out buffer of 64 entries, each 11 bits wide. The host drains the buffer one byte per read strobe. The error flags of the oldest character are shown on a separate output, so the host can look at them before it pops that character.

A two-bit field selects the fill threshold for the receive-data interrupt. The threshold also sets the centre of a hysteresis band that drives an active-low request-to-send output. When the fill level climbs above the top of the band, the output goes high and pauses the remote transmitter. When the level drops below the bottom of the band, or the buffer empties, the output goes low again. Inside the band the output keeps its last value.

When buffering is switched off, the block acts as a single holding register. Flow control runs only when both of its enable inputs are high.

Top module: `uart_rx_flow_buffer`

## Requirements
- R1: Characters come out in arrival order. A read strobe on a non-empty buffer pops the head entry, and its data byte appears on `rd_data` after the next clock edge. `level` reports the number of stored characters, with a capacity of 64 when `fifo_on` is 1.
- R2: `in_ready` is always 1. A character offered with `in_valid` is stored if the buffer is below capacity, or if a pop happens in the same cycle. Otherwise it is dropped and `overrun` goes high and stays high until reset.
- R3: A read strobe on an empty buffer leaves `rd_data` and `level` unchanged.
- R4: `head_err` shows the three error flags of the head entry, and shows 0 when the buffer is empty.
- R5: With `fifo_on` at 0, the capacity is one character and the interrupt threshold is 1.
- R6: A change of `fifo_on` empties the buffer at the next clock edge. Reads and writes offered in that cycle are ignored, and `rd_data` keeps its value.
- R7: `trig_sel` picks the threshold: 0→8, 1→16, 2→32, 3→56. `rx_irq` equals (level ≥ threshold) in the same cycle, so it clears as soon as the level drops below the threshold.
- R8: With flow control on, `rts_n` goes to 1 at the clock edge after a cycle in which `level` exceeds min(threshold+8, 64).
- R9: With flow control on, a high `rts_n` returns to 0 at the clock edge after a cycle in which `level` is below max(threshold−8, 0), or `level` is 0.
- R10: Between those two points, `rts_n` keeps its previous value.
- R11: Flow control is on only when both `flow_en_a` and `flow_en_b` are 1. While it is off, `rts_n` is 0 from the next clock edge onward. After reset `rts_n` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| fifo_on | input | 1 | 1 = 64-entry buffer, 0 = single holding register |
| flow_en_a | input | 1 | First flow-control enable |
| flow_en_b | input | 1 | Second flow-control enable |
| trig_sel | input | 2 | Threshold select (8/16/32/56) |
| in_valid | input | 1 | Incoming character valid |
| in_ready | output | 1 | Always 1; a full buffer drops the character and flags overrun |
| in_data | input | 8 | Incoming data byte |
| in_err | input | 3 | Incoming per-character error flags |
| rd_en | input | 1 | Host read strobe (pop) |
| rd_data | output | 8 | Last popped data byte |
| head_err | output | 3 | Error flags of head entry |
| level | output | 7 | Stored character count |
| rx_irq | output | 1 | Receive-data interrupt |
| rts_n | output | 1 | Active-low request to send |
| overrun | output | 1 | Sticky dropped-character flag |

## Verification
The bench fills the buffer to capacity and keeps writing. A design that wraps its count or overwrites the tail would then lose order or never set `overrun`. It reads while empty, where a pointer underflow would show up as a changed `rd_data` or a jump in `level`. It sweeps the level up and down through each threshold's band. A design with a single threshold, or one that uses the wrong clamp at 8 or 56, would toggle `rts_n` in the wrong cycle or get stuck high after an 8-level threshold. It also toggles buffering mode and the two flow enables, where a missing flush or a missing enable gate would leave stale characters or a high `rts_n`.

// File: rtl/rxf_pkg.sv
package rxf_pkg;
  localparam int DATA_W = 8;
  localparam int ERR_W  = 3;
  localparam int HYST   = 8;

  typedef struct packed {
    logic [ERR_W-1:0]  err;
    logic [DATA_W-1:0] data;
  } rx_char_t;

  typedef enum logic {RTS_GO = 1'b0, RTS_HALT = 1'b1} rts_state_t;

  function automatic int unsigned trig_of(input logic [1:0] sel);
    case (sel)
      2'd0:    trig_of = 8;
      2'd1:    trig_of = 16;
      2'd2:    trig_of = 32;
      default: trig_of = 56;
    endcase
  endfunction
endpackage

// File: rtl/rxf_store.sv
module rxf_store
  import rxf_pkg::*;
#(
  parameter int DEPTH = 64,
  localparam int PTR_W = $clog2(DEPTH),
  localparam int LVL_W = $clog2(DEPTH + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             flush,
  input  logic             cap_one,
  input  logic             push_req,
  input  rx_char_t         push_char,
  input  logic             pop_req,
  output rx_char_t         head_char,
  output logic [LVL_W-1:0] count,
  output logic             push_fire,
  output logic             pop_fire
);
  rx_char_t         mem [DEPTH];
  logic [PTR_W-1:0] wr_ptr, rd_ptr;
  logic             full;

  function automatic logic [PTR_W-1:0] bump(input logic [PTR_W-1:0] p);
    return (p == PTR_W'(DEPTH - 1)) ? '0 : p + 1'b1;
  endfunction

  assign full      = cap_one ? (count != '0) : (count == LVL_W'(DEPTH));
  assign pop_fire  = pop_req && (count != '0) && !flush;
  assign push_fire = push_req && (!full || pop_fire) && !flush;
  assign head_char = mem[rd_ptr];

  always_ff @(posedge clk) begin
    if (push_fire) mem[wr_ptr] <= push_char;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wr_ptr <= '0;
      rd_ptr <= '0;
      count  <= '0;
    end else if (flush) begin
      wr_ptr <= '0;
      rd_ptr <= '0;
      count  <= '0;
    end else begin
      if (push_fire) wr_ptr <= bump(wr_ptr);
      if (pop_fire)  rd_ptr <= bump(rd_ptr);
      case ({push_fire, pop_fire})
        2'b10:   count <= count + 1'b1;
        2'b01:   count <= count - 1'b1;
        default: count <= count;
      endcase
    end
  end
endmodule

// File: rtl/rxf_level_watch.sv
module rxf_level_watch
  import rxf_pkg::*;
#(
  parameter int DEPTH = 64,
  localparam int LVL_W = $clog2(DEPTH + 1)
) (
  input  logic [LVL_W-1:0] level,
  input  logic             fifo_on,
  input  logic [1:0]       trig_sel,
  output logic             irq,
  output logic [LVL_W-1:0] hi_mark,
  output logic [LVL_W-1:0] lo_mark
);
  int unsigned eff, hi_i, lo_i;

  always_comb begin
    eff  = fifo_on ? trig_of(trig_sel) : 1;
    hi_i = (eff + HYST > DEPTH) ? DEPTH : eff + HYST;
    lo_i = (eff > HYST) ? eff - HYST : 0;
  end

  assign hi_mark = LVL_W'(hi_i);
  assign lo_mark = LVL_W'(lo_i);
  assign irq     = (32'(level) >= eff);
endmodule

// File: rtl/rxf_rts_ctl.sv
module rxf_rts_ctl
  import rxf_pkg::*;
#(
  parameter int LVL_W = 7
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             flow_on,
  input  logic [LVL_W-1:0] level,
  input  logic [LVL_W-1:0] hi_mark,
  input  logic [LVL_W-1:0] lo_mark,
  output logic             rts_n
);
  rts_state_t st;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        st <= RTS_GO;
    else if (!flow_on) st <= RTS_GO;
    else begin
      case (st)
        RTS_GO:   if (level > hi_mark) st <= RTS_HALT;
        RTS_HALT: if (level < lo_mark || level == '0) st <= RTS_GO;
        default:  st <= RTS_GO;
      endcase
    end
  end

  assign rts_n = (st == RTS_HALT);
endmodule

// File: rtl/uart_rx_flow_buffer.sv
module uart_rx_flow_buffer
  import rxf_pkg::*;
#(
  parameter int DEPTH = 64,
  localparam int LVL_W = $clog2(DEPTH + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              fifo_on,
  input  logic              flow_en_a,
  input  logic              flow_en_b,
  input  logic [1:0]        trig_sel,
  input  logic              in_valid,
  output logic              in_ready,
  input  logic [DATA_W-1:0] in_data,
  input  logic [ERR_W-1:0]  in_err,
  input  logic              rd_en,
  output logic [DATA_W-1:0] rd_data,
  output logic [ERR_W-1:0]  head_err,
  output logic [LVL_W-1:0]  level,
  output logic              rx_irq,
  output logic              rts_n,
  output logic              overrun
);
  logic       fifo_on_q, flush, push_fire, pop_fire;
  rx_char_t   head_char, in_char;
  logic [LVL_W-1:0] hi_mark, lo_mark;

  assign in_ready = 1'b1;
  assign flush    = (fifo_on != fifo_on_q);
  assign in_char  = '{err: in_err, data: in_data};

  rxf_store #(.DEPTH(DEPTH)) u_store (
    .clk(clk), .rst_n(rst_n), .flush(flush), .cap_one(!fifo_on),
    .push_req(in_valid), .push_char(in_char), .pop_req(rd_en),
    .head_char(head_char), .count(level),
    .push_fire(push_fire), .pop_fire(pop_fire)
  );

  rxf_level_watch #(.DEPTH(DEPTH)) u_watch (
    .level(level), .fifo_on(fifo_on), .trig_sel(trig_sel),
    .irq(rx_irq), .hi_mark(hi_mark), .lo_mark(lo_mark)
  );

  rxf_rts_ctl #(.LVL_W(LVL_W)) u_rts (
    .clk(clk), .rst_n(rst_n), .flow_on(flow_en_a && flow_en_b),
    .level(level), .hi_mark(hi_mark), .lo_mark(lo_mark), .rts_n(rts_n)
  );

  assign head_err = (level != '0) ? head_char.err : '0;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      fifo_on_q <= 1'b0;
      rd_data   <= '0;
      overrun   <= 1'b0;
    end else begin
      fifo_on_q <= fifo_on;
      if (pop_fire) rd_data <= head_char.data;
      if (in_valid && !flush && !push_fire) overrun <= 1'b1;
    end
  end
endmodule

// File: rtl/rxf_checker.sv
module rxf_checker #(
  parameter int DEPTH = 64,
  localparam int LVL_W = $clog2(DEPTH + 1)
) (
  input logic             clk,
  input logic             rst_n,
  input logic             fifo_on,
  input logic             flow_en_a,
  input logic             flow_en_b,
  input logic [1:0]       trig_sel,
  input logic             rd_en,
  input logic [7:0]       rd_data,
  input logic [2:0]       head_err,
  input logic [LVL_W-1:0] level,
  input logic             rx_irq,
  input logic             rts_n,
  input logic             overrun
);
  int unsigned eff_trig;
  always_comb begin
    if (!fifo_on) eff_trig = 1;
    else case (trig_sel)
      2'd0: eff_trig = 8;
      2'd1: eff_trig = 16;
      2'd2: eff_trig = 32;
      default: eff_trig = 56;
    endcase
  end

  assert_level_bound_R1: assert property (@(posedge clk) disable iff (!rst_n)
    32'(level) <= DEPTH);
  assert_overrun_sticky_R2: assert property (@(posedge clk) disable iff (!rst_n)
    overrun |=> overrun);
  assert_empty_read_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_en && level == '0) |=> $stable(rd_data));
  assert_head_err_empty_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (level == '0) |-> (head_err == '0));
  assert_hold_cap_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (!fifo_on && level <= 1) |=> (level <= 1));
  assert_irq_level_R7: assert property (@(posedge clk) disable iff (!rst_n)
    rx_irq == (32'(level) >= eff_trig));
  assert_rts_rise_R8: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rts_n) |-> ($past(level) > 16));
  assert_rts_fall_R9: assert property (@(posedge clk) disable iff (!rst_n)
    ($fell(rts_n) && $past(flow_en_a && flow_en_b)) |-> ($past(level) < 48));
  assert_rts_off_R11: assert property (@(posedge clk) disable iff (!rst_n)
    !(flow_en_a && flow_en_b) |=> !rts_n);
endmodule

bind uart_rx_flow_buffer rxf_checker #(.DEPTH(DEPTH)) i_rxf_checker (
  .clk(clk), .rst_n(rst_n), .fifo_on(fifo_on), .flow_en_a(flow_en_a),
  .flow_en_b(flow_en_b), .trig_sel(trig_sel), .rd_en(rd_en),
  .rd_data(rd_data), .head_err(head_err), .level(level),
  .rx_irq(rx_irq), .rts_n(rts_n), .overrun(overrun)
);

// File: tb/test_uart_rx_flow_buffer.sv
`timescale 1ns/1ps
module test_uart_rx_flow_buffer;
  logic clk = 1'b0, rst_n = 1'b0;
  logic fifo_on = 1'b1, flow_en_a = 1'b1, flow_en_b = 1'b1;
  logic [1:0] trig_sel = 2'd1;
  logic in_valid = 1'b0, rd_en = 1'b0, in_ready;
  logic [7:0] in_data = '0, rd_data;
  logic [2:0] in_err = '0, head_err;
  logic [6:0] level;
  logic rx_irq, rts_n, overrun;

  int checks = 0, errors = 0;
  bit done = 0;

  logic [10:0] q[$];
  logic [7:0] m_rd = '0;
  logic m_ovr = 0, m_rts = 0, m_fonq = 0;

  always #4 clk = ~clk;

  uart_rx_flow_buffer i_uart_rx_flow_buffer (
    .clk(clk), .rst_n(rst_n), .fifo_on(fifo_on), .flow_en_a(flow_en_a),
    .flow_en_b(flow_en_b), .trig_sel(trig_sel), .in_valid(in_valid),
    .in_ready(in_ready), .in_data(in_data), .in_err(in_err), .rd_en(rd_en),
    .rd_data(rd_data), .head_err(head_err), .level(level), .rx_irq(rx_irq),
    .rts_n(rts_n), .overrun(overrun)
  );

  function automatic int trig_val();
    if (!fifo_on) return 1;
    case (trig_sel)
      2'd0: return 8;
      2'd1: return 16;
      2'd2: return 32;
      default: return 56;
    endcase
  endfunction
  function automatic int hi_pt();
    return (trig_val() + 8 > 64) ? 64 : trig_val() + 8;
  endfunction
  function automatic int lo_pt();
    return (trig_val() > 8) ? trig_val() - 8 : 0;
  endfunction

  task automatic chk(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual=%0d expected=%0d at %0t", tag, act, exp, $time);
    end
  endtask

  task automatic check_all();
    chk("R1 level", level, q.size());
    chk("R1 rd_data", rd_data, m_rd);
    chk("R2 overrun", overrun, m_ovr);
    chk("R2 in_ready", in_ready, 1);
    chk("R4 head_err", head_err, q.size() ? q[0][10:8] : 0);
    chk("R7 rx_irq", rx_irq, int'(q.size()) >= trig_val());
    chk("R8 R9 R10 R11 rts_n", rts_n, m_rts);
  endtask

  // check current state, then drive one cycle of inputs and advance the model
  task automatic step(input bit v, input logic [7:0] d, input logic [2:0] e, input bit rd);
    bit flush, pop, push, flow;
    int cap, sz;
    check_all();
    in_valid = v; in_data = d; in_err = e; rd_en = rd;
    flow = flow_en_a && flow_en_b;
    sz = q.size();
    if (!flow) m_rts = 0;
    else if (!m_rts && sz > hi_pt()) m_rts = 1;
    else if (m_rts && (sz < lo_pt() || sz == 0)) m_rts = 0;
    flush = (fifo_on != m_fonq);
    m_fonq = fifo_on;
    if (flush) q.delete();
    else begin
      cap  = fifo_on ? 64 : 1;
      pop  = rd && sz > 0;
      push = v && (sz < cap || pop);
      if (v && !push) m_ovr = 1;
      if (pop) begin m_rd = q[0][7:0]; void'(q.pop_front()); end
      if (push) q.push_back({e, d});
    end
    @(negedge clk);
  endtask

  task automatic do_reset();
    rst_n = 0; in_valid = 0; rd_en = 0;
    q.delete(); m_rd = 0; m_ovr = 0; m_rts = 0; m_fonq = 0;
    repeat (2) @(negedge clk);
    rst_n = 1;
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("  Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++; checks++;
    $display("FAIL watchdog: actual=timeout expected=finish");
    finish_run();
  end

  initial begin
    void'($urandom(32'h5eed_1234));
    @(negedge clk);
    do_reset();
    // reset state (R1, R11); first cycle after reset flushes due to mode register
    check_all();
    chk("R11 reset rts_n", rts_n, 0);
    // R3: empty reads do nothing
    for (int i = 0; i < 4; i++) step(0, 0, 0, 1);
    chk("R3 empty rd_data", rd_data, 0);
    // R2: fill to 64 and beyond, R8 with trigger 16
    for (int i = 0; i < 70; i++) step(1, 8'(i + 1), 3'(i), 0);
    step(0, 0, 0, 0);
    chk("R2 full level", level, 64);
    chk("R2 overrun set", overrun, 1);
    chk("R8 rts high when full", rts_n, 1);
    // R1 order, R9 drain
    for (int i = 0; i < 64; i++) step(0, 0, 0, 1);
    step(0, 0, 0, 0);
    chk("R1 last popped", rd_data, 64);
    chk("R9 rts low when empty", rts_n, 0);
    chk("R2 overrun sticky", overrun, 1);
    // R8/R10 with trigger 8: clamp low point to 0
    do_reset();
    trig_sel = 2'd0;
    for (int i = 0; i < 20; i++) step(1, 8'($urandom), 3'($urandom), 0);
    for (int i = 0; i < 19; i++) step(0, 0, 0, 1);
    chk("R10 rts held at level 1", rts_n, 1);
    step(0, 0, 0, 1); step(0, 0, 0, 0);
    chk("R9 rts low at empty", rts_n, 0);
    // R11: one enable off keeps rts low
    do_reset();
    flow_en_b = 0;
    for (int i = 0; i < 40; i++) step(1, 8'($urandom), 3'($urandom), 0);
    step(0, 0, 0, 0);
    chk("R11 rts low when disabled", rts_n, 0);
    flow_en_b = 1;
    step(0, 0, 0, 0); step(0, 0, 0, 0);
    chk("R11 rts high once enabled", rts_n, 1);
    // R6: mode change flushes; R5 holding register
    fifo_on = 0;
    step(0, 0, 0, 0);
    chk("R6 flushed", level, 0);
    for (int i = 0; i < 3; i++) step(1, 8'(8'hA0 + i), 3'd5, 0);
    chk("R5 cap one", level, 1);
    chk("R5 irq at one", rx_irq, 1);
    step(0, 0, 0, 1); step(0, 0, 0, 0);
    chk("R5 holding data", rd_data, 8'hA0);
    fifo_on = 1;
    step(0, 0, 0, 0);
    // random sweeps over all thresholds with fill/drain bias
    for (int ph = 0; ph < 24; ph++) begin
      int bias = (ph % 2) ? 25 : 75;
      if (ph % 6 == 5) do_reset();
      trig_sel = 2'($urandom_range(0, 3));
      flow_en_a = ($urandom_range(0, 7) != 0);
      for (int c = 0; c < 150; c++)
        step($urandom_range(0, 99) < bias, 8'($urandom), 3'($urandom),
             $urandom_range(0, 99) >= bias);
    end
    check_all();
    finish_run();
  end
endmodule